// File: doc/BRIEF.md
# Two-Stage Fetch Front End with Redirect Squash

This block is the instruction-supply end of a 32-bit, two-stage RISC-V style core. The first stage keeps a program counter and presents it as a byte fetch address. The instruction word that comes back is captured in a pipeline register, along with the address it came from. Both are then offered to the execute stage, together with the link value that address plus four gives.

The second stage decodes the opcode and funct3 of the held instruction, and the execute logic feeds in the two register operands and the decoded immediate. From these the block decides whether control flow leaves the sequential path. Conditional branches compare the operands. Direct and register-indirect jumps always redirect. On a redirect, the program counter takes the target. On the same clock edge, the word fetched in the wrong-path slot is replaced by the canonical no-op, so that it never executes.

Redirects are worked out only in the second stage. The block does not stall and does not predict. Every taken branch or jump costs exactly one squashed slot, and a branch that is not taken costs nothing.

Top module: `branch_kill_front`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next edge sets fetchAddr to 0, exInstr to the no-op word 0x00000013 and exPc to 0.
- R2: With no redirect, fetchAddr advances by 4 on every edge, and exInstr/exPc take the word presented on fetchInstr in the previous cycle and the address it was fetched from.
- R3: An exInstr with opcode bits [6:0] = 0x63 is a conditional branch, and its funct3 field sits in bits [14:12]. funct3 0x0 is taken when rs1Val equals rs2Val, and funct3 0x1 is taken when they differ.
- R4: Under opcode 0x63, funct3 0x4 is taken when rs1Val is less than rs2Val as signed numbers, and funct3 0x6 is taken when it is less as unsigned numbers.
- R5: A branch that is not taken, or one whose funct3 is any other value, causes no redirect: the fetched word reaches exInstr unchanged and fetchAddr keeps stepping by 4.
- R6: On a redirect, the next edge loads the target into fetchAddr and puts 0x00000013 on exInstr in place of the word fetched that cycle.
- R7: The target of a taken branch, and of opcode 0x6F (direct jump, always redirects), is exPc plus immVal shifted left by one bit.
- R8: Opcode 0x67 with funct3 0x0 (register jump) always redirects to rs1Val plus immVal with bit 0 cleared.
- R9: exLink always equals exPc plus 4.
- R10: Reset asserted in the middle of a run returns the block to the R1 state on the next edge, and fetch restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchInstr | input | 32 | Instruction word stored at fetchAddr |
| rs1Val | input | 32 | First register operand of the execute-stage instruction |
| rs2Val | input | 32 | Second register operand of the execute-stage instruction |
| immVal | input | 32 | Sign-extended immediate of the execute-stage instruction |
| fetchAddr | output | 32 | Byte address of the instruction being fetched |
| exInstr | output | 32 | Instruction word in the execute stage |
| exPc | output | 32 | Address of the execute-stage instruction |
| exLink | output | 32 | Return address exPc + 4 for jump write-back |

## Verification
A corrupted program counter is visible on fetchAddr in the same cycle, and one cycle later it also shows on exPc and exLink. A redirect that is missed or spurious shows on the edge that follows the offending execute cycle in two ways: exInstr carries the fetched word instead of 0x00000013 (or the reverse), and fetchAddr continues sequentially instead of jumping to the target. The bench walks a program through every branch condition, taken and not taken, and through both kinds of jump. At each cycle it compares all four outputs against a queue of expected slots. Because of this, a fault in the compare, decode or target arithmetic shows up within one cycle of the instruction that triggers it.

// File: rtl/front_pkg.sv
package front_pkg;

  localparam int unsigned ILEN = 32;

  localparam logic [ILEN-1:0] NOP_WORD = 32'h0000_0013;

  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_JUMP   = 7'h6F;
  localparam logic [6:0] OPC_REGJMP = 7'h67;

  localparam logic [2:0] CMP_EQ  = 3'h0;
  localparam logic [2:0] CMP_NE  = 3'h1;
  localparam logic [2:0] CMP_LT  = 3'h4;
  localparam logic [2:0] CMP_LTU = 3'h6;

  // Strobes from the redirect control into the fetch datapath.
  typedef struct packed {
    logic kill;        // squash the fetched word and take the target
    logic useRegBase;  // target is register plus immediate, not pc-relative
  } redirStrobe_t;

endpackage

// File: rtl/branchCompare.sv
module branchCompare
  import front_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic [2:0]      cmpSel,
  output logic            taken
);

  logic isEqual;
  logic isLessSigned;
  logic isLessUnsigned;

  assign isEqual        = (lhs == rhs);
  assign isLessSigned   = ($signed(lhs) < $signed(rhs));
  assign isLessUnsigned = (lhs < rhs);

  always_comb begin
    case (cmpSel)
      CMP_EQ:  taken = isEqual;
      CMP_NE:  taken = !isEqual;
      CMP_LT:  taken = isLessSigned;
      CMP_LTU: taken = isLessUnsigned;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/redirectControl.sv
module redirectControl
  import front_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [6:0]      opcode,
  input  logic [2:0]      funct3,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  output redirStrobe_t    strobes
);

  logic isBranch;
  logic isJump;
  logic isRegJump;
  logic condMet;

  assign isBranch  = (opcode == OPC_BRANCH);
  assign isJump    = (opcode == OPC_JUMP);
  assign isRegJump = (opcode == OPC_REGJMP) && (funct3 == 3'h0);

  branchCompare #(.XLEN(XLEN)) u_cmp (
    .lhs    (rs1Val),
    .rhs    (rs2Val),
    .cmpSel (funct3),
    .taken  (condMet)
  );

  always_comb begin
    strobes.kill       = isJump || isRegJump || (isBranch && condMet);
    strobes.useRegBase = isRegJump;
  end

endmodule

// File: rtl/fetchDatapath.sv
module fetchDatapath
  import front_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  redirStrobe_t    strobes,
  input  logic [ILEN-1:0] fetchInstr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] immVal,
  output logic [XLEN-1:0] fetchAddr,
  output logic [ILEN-1:0] exInstr,
  output logic [XLEN-1:0] exPc,
  output logic [XLEN-1:0] exLink
);

  localparam logic [XLEN-1:0] STEP      = XLEN'(4);
  localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

  logic [XLEN-1:0] pcReg;
  logic [XLEN-1:0] exPcReg;
  logic [ILEN-1:0] instrReg;
  logic [XLEN-1:0] relTarget;
  logic [XLEN-1:0] regTarget;
  logic [XLEN-1:0] redirTarget;
  logic [XLEN-1:0] nextPc;

  assign relTarget   = exPcReg + (immVal << 1);
  assign regTarget   = (rs1Val + immVal) & EVEN_MASK;
  assign redirTarget = strobes.useRegBase ? regTarget : relTarget;
  assign nextPc      = strobes.kill ? redirTarget : (pcReg + STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg    <= RESET_PC;
      exPcReg  <= RESET_PC;
      instrReg <= NOP_WORD;
    end else begin
      pcReg    <= nextPc;
      exPcReg  <= pcReg;
      instrReg <= strobes.kill ? NOP_WORD : fetchInstr;
    end
  end

  assign fetchAddr = pcReg;
  assign exInstr   = instrReg;
  assign exPc      = exPcReg;
  assign exLink    = exPcReg + STEP;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pcReg == RESET_PC && exPcReg == RESET_PC && instrReg == NOP_WORD));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.kill |=> (pcReg == $past(pcReg) + STEP));

  assert_ex_pc_follows_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (exPcReg == $past(pcReg)));

  assert_squash_nop_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.kill |=> (instrReg == NOP_WORD));

  assert_pc_even_R8: assert property (@(posedge clk) disable iff (rst)
    pcReg[0] == 1'b0);

endmodule

// File: rtl/branch_kill_front.sv
module branch_kill_front
  import front_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     fetchInstr,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [XLEN-1:0] immVal,
  output logic [XLEN-1:0] fetchAddr,
  output logic [31:0]     exInstr,
  output logic [XLEN-1:0] exPc,
  output logic [XLEN-1:0] exLink
);

  redirStrobe_t strobes;
  logic [ILEN-1:0] exInstrW;

  redirectControl #(.XLEN(XLEN)) u_ctrl (
    .opcode  (exInstrW[6:0]),
    .funct3  (exInstrW[14:12]),
    .rs1Val  (rs1Val),
    .rs2Val  (rs2Val),
    .strobes (strobes)
  );

  fetchDatapath #(.XLEN(XLEN)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .fetchInstr (fetchInstr),
    .rs1Val     (rs1Val),
    .immVal     (immVal),
    .fetchAddr  (fetchAddr),
    .exInstr    (exInstrW),
    .exPc       (exPc),
    .exLink     (exLink)
  );

  assign exInstr = exInstrW;

endmodule

// File: tb/branch_kill_front_bench.sv
module branch_kill_front_bench;

  localparam logic [31:0] NOP = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchInstr, rs1Val, rs2Val, immVal;
  logic [31:0] fetchAddr, exInstr, exPc, exLink;

  int checks = 0;
  int errors = 0;
  bit monitorOn = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] pc;
    bit          squashed;
    logic [31:0] nextPc;
    string       tag;
  } slot_t;

  slot_t sb[$];

  always #2 clk = ~clk;

  branch_kill_front u_branch_kill_front (
    .clk        (clk),
    .rst        (rst),
    .fetchInstr (fetchInstr),
    .rs1Val     (rs1Val),
    .rs2Val     (rs2Val),
    .immVal     (immVal),
    .fetchAddr  (fetchAddr),
    .exInstr    (exInstr),
    .exPc       (exPc),
    .exLink     (exLink)
  );

  function automatic logic [31:0] brWord(input logic [2:0] f3);
    return {17'b0, f3, 5'b0, 7'h63};
  endfunction

  // Program image: distinct addi x1,x0,addr by default.
  function automatic logic [31:0] progWord(input logic [31:0] a);
    case (a)
      32'h004: return brWord(3'h0);
      32'h020: return brWord(3'h1);
      32'h024: return brWord(3'h4);
      32'h040: return brWord(3'h6);
      32'h044: return brWord(3'h6);
      32'h034: return brWord(3'h2);
      32'h038: return 32'h0000_006F;
      32'h078: return 32'h0000_0067;
      32'h110: return brWord(3'h0);
      32'h114: return brWord(3'h4);
      32'h118: return brWord(3'h1);
      default: return 32'h0000_0093 | {a[11:0], 20'b0};
    endcase
  endfunction

  assign fetchInstr = progWord(fetchAddr);

  always_comb begin
    rs1Val = '0; rs2Val = '0; immVal = '0;
    case (exPc)
      32'h004: begin rs1Val = 32'd5;        rs2Val = 32'd5;        immVal = 32'h0E; end
      32'h020: begin rs1Val = 32'd5;        rs2Val = 32'd5;        immVal = 32'h0E; end
      32'h024: begin rs1Val = 32'hFFFFFFFF; rs2Val = 32'd1;        immVal = 32'h0E; end
      32'h040: begin rs1Val = 32'hFFFFFFFF; rs2Val = 32'd1;        immVal = 32'h0E; end
      32'h044: begin rs1Val = 32'd1;        rs2Val = 32'hFFFFFFFF; immVal = 32'hFFFFFFF8; end
      32'h034: begin rs1Val = 32'd7;        rs2Val = 32'd7;        immVal = 32'h0E; end
      32'h038: begin immVal = 32'h20; end
      32'h078: begin rs1Val = 32'h101;      immVal = 32'h10; end
      32'h110: begin rs1Val = 32'd1;        rs2Val = 32'd2;        immVal = 32'h0E; end
      32'h114: begin rs1Val = 32'd1;        rs2Val = 32'hFFFFFFFF; immVal = 32'h0E; end
      32'h118: begin rs1Val = 32'd3;        rs2Val = 32'd4;        immVal = 32'h0E; end
      default: ;
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] pc, input bit sq, input logic [31:0] nxt, input string tag);
    slot_t s;
    s.pc = pc; s.squashed = sq; s.nextPc = nxt; s.tag = tag;
    sb.push_back(s);
  endtask

  // Monitor: one expected slot per cycle after each edge.
  always @(negedge clk) begin
    if (monitorOn && sb.size() > 0) begin
      slot_t s;
      s = sb.pop_front();
      chk({s.tag, " exPc"}, exPc, s.pc);
      chk({s.tag, " exInstr"}, exInstr, s.squashed ? NOP : progWord(s.pc));
      chk("R9 exLink", exLink, s.pc + 32'd4);
      chk({s.tag, " fetchAddr"}, fetchAddr, s.nextPc);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fetchAddr", fetchAddr, 32'h0);
    chk("R1 exInstr", exInstr, NOP);
    chk("R1 exPc", exPc, 32'h0);

    push(32'h000, 0, 32'h004, "R2");
    push(32'h004, 0, 32'h008, "R3 beq taken");
    push(32'h008, 1, 32'h020, "R6 R7 squash");
    push(32'h020, 0, 32'h024, "R3 R5 bne not taken");
    push(32'h024, 0, 32'h028, "R4 blt taken");
    push(32'h028, 1, 32'h040, "R6 R4 squash");
    push(32'h040, 0, 32'h044, "R4 R5 bltu not taken");
    push(32'h044, 0, 32'h048, "R4 bltu taken");
    push(32'h048, 1, 32'h034, "R7 negative offset");
    push(32'h034, 0, 32'h038, "R5 other funct3");
    push(32'h038, 0, 32'h03C, "R7 jal");
    push(32'h03C, 1, 32'h078, "R7 jal squash");
    push(32'h078, 0, 32'h07C, "R8 jalr");
    push(32'h07C, 1, 32'h110, "R8 jalr bit0 cleared");
    push(32'h110, 0, 32'h114, "R5 beq not taken");
    push(32'h114, 0, 32'h118, "R4 R5 blt not taken");
    push(32'h118, 0, 32'h11C, "R3 bne taken");
    push(32'h11C, 1, 32'h134, "R6 bne squash");
    push(32'h134, 0, 32'h138, "R2 after redirect");
    push(32'h138, 0, 32'h13C, "R2");

    rst = 1'b0;
    @(posedge clk);
    monitorOn = 1'b1;
    wait (sb.size() == 0);
    @(negedge clk);
    monitorOn = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R10 fetchAddr", fetchAddr, 32'h0);
    chk("R10 exInstr", exInstr, NOP);
    chk("R10 exPc", exPc, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 restart exPc", exPc, 32'h0);
    chk("R10 restart exInstr", exInstr, progWord(32'h0));
    chk("R10 restart fetchAddr", fetchAddr, 32'h4);
    summary();
  end

endmodule